// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a third table choose between them for each branch. The first component is a table of 2-bit saturating counters addressed by low bits of the branch address. The second component is a table of 2-bit saturating counters addressed by a shift register of recent actual branch outcomes. A chooser table of 2-bit counters, also addressed by the branch address, decides which component's answer becomes the final prediction.

A fetch stage presents a PC on the lookup side and receives, in the same cycle and with no register in between, the final prediction, both component predictions and the selected source. When the branch resolves, the pipeline returns the PC, the real outcome and the two component predictions it saved at lookup time. Both components train on every resolved branch. The chooser trains only when the two saved predictions differ, and it moves toward the component that was right. A flush input, used on a context switch, returns every table and the history register to their reset contents.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every counter in both components holds 01 (weakly not taken), every chooser counter holds 01 (weakly favouring the bimodal component), and the history register is zero; lookups then report both component predictions as not taken and the selected source as bimodal.
- R2: The bimodal component is addressed by PC bits [BIM_W-1:0].
- R3: The global component is addressed by the whole history register; each accepted update shifts the history left by one and places the actual outcome (1 = taken) in bit 0.
- R4: Every counter is a 2-bit saturating counter: a taken outcome adds one unless it is 11, a not-taken outcome subtracts one unless it is 00, and a counter predicts taken when its value is 10 or 11.
- R5: On every accepted update both component counters train toward the outcome, whichever component was selected; the global entry trained is the one addressed by the history value before the shift.
- R6: The chooser is addressed by PC bits [SEL_W-1:0]; a chooser value of 10 or 11 selects the global component (lk_use_glb = 1), 00 or 01 selects the bimodal component, and lk_pred equals the selected component's prediction.
- R7: The chooser entry changes only when the saved predictions disagree; it then adds one when the global prediction matched the outcome and subtracts one otherwise. When they agree the chooser is unchanged.
- R8: A flush restores the full R1 state on the next cycle and takes priority over an update presented in the same cycle.
- R9: A lookup reads table and history contents from before any update applied at the same clock edge; an update becomes visible to lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Context-switch clear of all tables and history |
| lk_pc | input | PC_W | Lookup branch address |
| lk_pred | output | 1 | Final predicted direction (1 = taken) |
| lk_bim_pred | output | 1 | Bimodal component prediction |
| lk_glb_pred | output | 1 | Global-history component prediction |
| lk_use_glb | output | 1 | Selected source (1 = global, 0 = bimodal) |
| up_valid | input | 1 | Resolved branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_bim_pred | input | 1 | Bimodal prediction saved at lookup |
| up_glb_pred | input | 1 | Global prediction saved at lookup |

## Verification
Every internal state of this block reaches the ports through a lookup in the cycle after it is written: a wrong bimodal or chooser counter shows on lk_bim_pred or lk_use_glb as soon as the matching PC is looked up, and a wrong history value redirects lk_glb_pred for every PC at once. The bench therefore looks up a PC on every cycle and compares all four lookup outputs against a behavioural model, so a corrupted counter or history bit shows up within one lookup of its address. Saturation, disagreement-only chooser training, flush priority and same-cycle read-before-write each get directed sequences in addition to a long random run with heavy address aliasing.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_LO = 2'b01;
    localparam ctr2_t CTR_MAX     = 2'b11;
    localparam ctr2_t CTR_MIN     = 2'b00;

    typedef struct packed {
        logic pred;
        logic bim;
        logic glb;
        logic use_glb;
    } lookup_t;

    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t n;
        n = c;
        if (up && (c != CTR_MAX)) n = c + 2'd1;
        if (!up && (c != CTR_MIN)) n = c - 2'd1;
        return n;
    endfunction

    function automatic logic ctr_says_hi(input ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/ctr_table.sv
module ctr_table
    import bp_pkg::*;
#(
    parameter int    IDX_W   = 6,
    parameter ctr2_t RST_VAL = CTR_WEAK_LO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_inc
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_inc);
        end
    end

    assign rd_ctr = mem[rd_idx];

    AST_CLR_RESTORES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rd_ctr == RST_VAL)); // R8

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_en && wr_inc && mem[wr_idx] == CTR_MAX)
            |=> (mem[$past(wr_idx)] == CTR_MAX)); // R4

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_en && !wr_inc && mem[wr_idx] == CTR_MIN)
            |=> (mem[$past(wr_idx)] == CTR_MIN)); // R4

endmodule

// File: rtl/hist_reg.sv
module hist_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst || clr)     hist <= '0;
        else if (shift_en)  hist <= {hist[W-2:0], bit_in};
    end

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clr) |=> (hist[0] == $past(bit_in))); // R3

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clr) |=> $stable(hist)); // R3

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int BIM_W  = 6,
    parameter int HIST_W = 6,
    parameter int SEL_W  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_pred,
    output logic            lk_bim_pred,
    output logic            lk_glb_pred,
    output logic            lk_use_glb,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_bim_pred,
    input  logic            up_glb_pred
);
    logic [HIST_W-1:0] ghist;
    ctr2_t             bim_ctr, glb_ctr, sel_ctr;
    lookup_t           res;

    logic accept;
    logic sel_train;
    logic glb_was_right;

    assign accept        = up_valid && !flush;
    assign sel_train     = accept && (up_bim_pred != up_glb_pred);
    assign glb_was_right = (up_glb_pred == up_taken);

    hist_reg #(.W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .clr      (flush),
        .shift_en (accept),
        .bit_in   (up_taken),
        .hist     (ghist)
    );

    ctr_table #(.IDX_W(BIM_W), .RST_VAL(CTR_WEAK_LO)) u_bim (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .rd_idx (lk_pc[BIM_W-1:0]),
        .rd_ctr (bim_ctr),
        .wr_en  (accept),
        .wr_idx (up_pc[BIM_W-1:0]),
        .wr_inc (up_taken)
    );

    ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WEAK_LO)) u_glb (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .rd_idx (ghist),
        .rd_ctr (glb_ctr),
        .wr_en  (accept),
        .wr_idx (ghist),
        .wr_inc (up_taken)
    );

    ctr_table #(.IDX_W(SEL_W), .RST_VAL(CTR_WEAK_LO)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .rd_idx (lk_pc[SEL_W-1:0]),
        .rd_ctr (sel_ctr),
        .wr_en  (sel_train),
        .wr_idx (up_pc[SEL_W-1:0]),
        .wr_inc (glb_was_right)
    );

    always_comb begin
        res.bim     = ctr_says_hi(bim_ctr);
        res.glb     = ctr_says_hi(glb_ctr);
        res.use_glb = ctr_says_hi(sel_ctr);
        res.pred    = res.use_glb ? res.glb : res.bim;
    end

    assign lk_pred     = res.pred;
    assign lk_bim_pred = res.bim;
    assign lk_glb_pred = res.glb;
    assign lk_use_glb  = res.use_glb;

    AST_FLUSH_STATE: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!lk_use_glb && !lk_bim_pred && !lk_glb_pred && !lk_pred)); // R1

    AST_AGREE_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !flush && up_bim_pred == up_glb_pred && lk_pc == up_pc)
            |=> (lk_pc != $past(lk_pc) || $stable(lk_use_glb))); // R7

endmodule

// File: tb/sim_tournament_bp.sv
module sim_tournament_bp;
    localparam int PC_W = 32;
    localparam int IW   = 6;
    localparam int MSK  = (1 << IW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic lk_pred, lk_bim_pred, lk_glb_pred, lk_use_glb;
    logic up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic up_taken = 1'b0, up_bim_pred = 1'b0, up_glb_pred = 1'b0;

    always #10 clk = ~clk;

    tournament_bp #(.PC_W(PC_W), .BIM_W(IW), .HIST_W(IW), .SEL_W(IW)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .lk_pc(lk_pc),
        .lk_pred(lk_pred), .lk_bim_pred(lk_bim_pred),
        .lk_glb_pred(lk_glb_pred), .lk_use_glb(lk_use_glb),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_bim_pred(up_bim_pred), .up_glb_pred(up_glb_pred)
    );

    int m_bim [64];
    int m_glb [64];
    int m_sel [64];
    int m_hist;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic last_b, last_g;

    function automatic int sat(input int c, input bit up);
        if (up) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 64; i++) begin
            m_bim[i] = 1; m_glb[i] = 1; m_sel[i] = 1;
        end
        m_hist = 0;
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic [PC_W-1:0] pc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic ut,
                        input logic ub, input logic ug, input logic fl);
        logic eb, eg, es;
        int bi, si;
        @(negedge clk);
        lk_pc = pc; up_valid = uv; up_pc = upc; up_taken = ut;
        up_bim_pred = ub; up_glb_pred = ug; flush = fl;
        #2;
        eb = (m_bim[int'(pc) & MSK] >= 2);
        eg = (m_glb[m_hist] >= 2);
        es = (m_sel[int'(pc) & MSK] >= 2);
        chk("R2 R4 bimodal prediction", lk_bim_pred, eb);
        chk("R3 R5 global prediction", lk_glb_pred, eg);
        chk("R7 selected source", lk_use_glb, es);
        chk("R6 final prediction", lk_pred, es ? eg : eb);
        last_b = eb; last_g = eg;
        @(posedge clk);
        if (fl) model_clear();
        else if (uv) begin
            bi = int'(upc) & MSK;
            si = int'(upc) & MSK;
            m_bim[bi] = sat(m_bim[bi], ut);
            m_glb[m_hist] = sat(m_glb[m_hist], ut);
            if (ub != ug) m_sel[si] = sat(m_sel[si], (ug == ut));
            m_hist = ((m_hist << 1) | int'(ut)) & MSK;
        end
    endtask

    // lookup then resolve one branch using the predictions just seen
    task automatic branch(input logic [PC_W-1:0] pc, input logic t);
        step(pc, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(pc, 1'b1, pc, t, last_b, last_g, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic keep;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state visible on several addresses
        for (int i = 0; i < 4; i++) step(32'(i * 17), 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 reset source is bimodal", lk_use_glb, 1'b0);

        // R4: saturation at the top, one not-taken keeps prediction taken
        for (int i = 0; i < 6; i++) branch(32'h10, 1'b1);
        branch(32'h10, 1'b0);
        step(32'h10, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 hysteresis keeps taken", lk_bim_pred, 1'b1);
        // saturation at the bottom
        for (int i = 0; i < 6; i++) branch(32'h11, 1'b0);
        branch(32'h11, 1'b1);
        step(32'h11, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 hysteresis keeps not taken", lk_bim_pred, 1'b0);

        // R2: address aliasing on low bits
        step(32'h10 + 32'(64), 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 aliased PC shares bimodal entry", lk_bim_pred, 1'b1);

        // R6 R7 R5: alternating pattern, global component should win the chooser
        for (int i = 0; i < 40; i++) branch(32'h22, 1'(i & 1));

        // R7: agreeing updates leave chooser untouched
        step(32'h05, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        keep = lk_use_glb;
        for (int i = 0; i < 5; i++) step(32'h05, 1'b1, 32'h05, 1'b1, 1'b0, 1'b0, 1'b0);
        step(32'h05, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 chooser unchanged on agreement", lk_use_glb, keep);
        // R7: disagreement with global right moves chooser to global
        step(32'h05, 1'b1, 32'h05, 1'b1, 1'b0, 1'b1, 1'b0);
        step(32'h05, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 chooser moves to global", lk_use_glb, 1'b1);

        // R9: lookup and update on the same PC in the same cycle
        step(32'h07, 1'b1, 32'h07, 1'b1, 1'b0, 1'b1, 1'b0);
        step(32'h07, 1'b1, 32'h07, 1'b1, 1'b0, 1'b1, 1'b0);
        step(32'h07, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 update visible next cycle", lk_bim_pred, 1'b1);

        // R8: flush beats a simultaneous update
        step(32'h22, 1'b1, 32'h22, 1'b1, 1'b0, 1'b1, 1'b1);
        step(32'h22, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 flush restores bimodal source", lk_use_glb, 1'b0);
        step(32'h10, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 flush clears trained counter", lk_bim_pred, 1'b0);

        // random mix with heavy aliasing, checked every cycle
        for (int i = 0; i < 3000; i++) begin
            step(32'($urandom & 32'hFF), 1'($urandom), 32'($urandom & 32'hFF),
                 1'($urandom), 1'($urandom), 1'($urandom),
                 1'(($urandom % 200) == 0));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule